// File: doc/BRIEF.md
# Interleaved Memory Line-Fill Controller

This controller fetches one four-word cache line from a main memory that is built from slow banks. Time is counted in bus cycles. A requester offers a line address through a valid/ready handshake. The controller then spends one cycle sending the address and waits out the fixed bank latency. It returns the four words one per bus cycle, each with a valid strobe, a beat index and a last flag on the final word. The bank contents are a fixed function of the word address, so the memory needs no storage.

A mode bit, sampled together with the address, picks one of two organisations:

- **Sequential mode** models a one-word-wide memory. Each word needs its own bank access followed by its own transfer, so a line costs 1 + 4×(15+1) = 65 cycles.
- **Interleaved mode** models four banks that start their accesses together in the address cycle. The words then stream back on four consecutive cycles, so a line costs 1 + 15 + 4 = 20 cycles.

A penalty register records the length of the last completed fill.

The sequencer has four states:

- `ST_IDLE`: ready for a request.
- `ST_ADDR`: the address transfer.
- `ST_ACCESS`: waiting for the bank latency.
- `ST_XFER`: one word on the bus.

It has these transitions:

- IDLE→ADDR on acceptance.
- ADDR→ACCESS always.
- ACCESS→XFER when the bank serving the current beat finishes.
- XFER→ACCESS in sequential mode before the last beat.
- XFER→XFER in interleaved mode before the last beat.
- XFER→IDLE after the last beat.

Top module: `linefill_ctrl`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, rsp_last is 0 and penalty_cycles is 0.
- R2: A request is taken only on a clock edge where both req_valid and req_ready are 1. req_ready stays 0 from that edge until the fill completes. req_valid pulses while req_ready is 0 start nothing.
- R3: req_line and req_interleave are captured at acceptance. Changing them during a fill has no effect on that fill's data, timing or penalty.
- R4: Number the cycles from acceptance, where cycle 1 is the first cycle after the accepting edge. In sequential mode (req_interleave=0), word k (k=0..3) is valid in cycle 17+16k, and rsp_valid is 0 in every other cycle of the fill.
- R5: In interleaved mode (req_interleave=1), the four words are valid in cycles 17, 18, 19 and 20, back to back.
- R6: Words arrive in order. rsp_beat equals the word index 0..3, and rsp_last is 1 only together with beat 3.
- R7: The word for word address W = req_line×4 + beat is ((W zero-extended to 32 bits) × 0x9E3779B1 mod 2^32) XOR 0x5A5A0F0F.
- R8: In the cycle after the last word, req_ready is 1 again and penalty_cycles holds the fill length: 65 in sequential mode, 20 in interleaved mode. penalty_cycles holds that value until the next fill completes.
- R9: Asserting rst_n low in the middle of a fill aborts it. The controller returns to the state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_line | input | LINE_W | Line address of the fill |
| req_interleave | input | 1 | 1 = four-bank interleaved, 0 = one-word sequential |
| rsp_valid | output | 1 | rsp_data carries a word this cycle |
| rsp_data | output | 32 | Returned word |
| rsp_beat | output | 2 | Index of the returned word within the line |
| rsp_last | output | 1 | Final word of the line |
| penalty_cycles | output | CNT_W | Length in cycles of the last completed fill |

## Verification
Every result is due at a cycle counted from the accepting edge, and the bench checks each one there:

- Cycle 1 is the address cycle.
- The first word appears in cycle 17.
- Later words appear every 16 cycles in sequential mode, or every cycle in interleaved mode.
- The penalty value and the return of ready appear one cycle after the last word.

The bench counts cycles from the accepting edge and samples every cycle of the fill on the falling clock edge. In each cycle it compares the strobe, beat, last flag and data against a schedule computed from the mode. While the fill runs, it toggles the mode, the line and spurious request pulses, which must leave the results unchanged.

// File: rtl/linefill_pkg.sv
package linefill_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACCESS,
        ST_XFER
    } fill_state_e;

    // Content of main memory as a pure function of the word address.
    function automatic logic [DATA_W-1:0] mem_word(input logic [31:0] waddr);
        logic [31:0] prod;
        prod = waddr * 32'h9E37_79B1;
        return prod ^ 32'h5A5A_0F0F;
    endfunction

endpackage

// File: rtl/linefill_bank.sv
module linefill_bank
    import linefill_pkg::*;
#(
    parameter int LAT     = 15,
    parameter int WADDR_W = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [WADDR_W-1:0]   waddr,
    output logic                 done,
    output logic [DATA_W-1:0]    data
);

    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0]      remain_q;
    logic [WADDR_W-1:0] addr_q;
    logic [DATA_W-1:0]  data_q;

    // Countdown of the access latency; the final cycle raises done.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
            addr_q   <= '0;
        end else if (start) begin
            remain_q <= CW'(LAT);
            addr_q   <= waddr;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign done = (remain_q == CW'(1));

    // Data register loads at the end of the access and holds.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (done) begin
            data_q <= mem_word(32'(addr_q));
        end
    end

    assign data = data_q;

endmodule

// File: rtl/linefill_fsm.sv
module linefill_fsm
    import linefill_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              interleave,
    input  logic [NBANK-1:0]  bank_done,
    output logic [NBANK-1:0]  bank_start,
    output logic [BEAT_W-1:0] beat,
    output logic              busy,
    output logic              word_valid,
    output logic              word_last
);

    fill_state_e state_q, state_d;
    logic [BEAT_W-1:0] beat_q;
    logic              final_beat;

    assign final_beat = (beat_q == BEAT_W'(NBANK - 1));

    // State register and beat counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                beat_q <= '0;
            end else if (state_q == ST_XFER && !final_beat) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_ADDR;
            ST_ADDR:   state_d = ST_ACCESS;
            ST_ACCESS: if (bank_done[beat_q]) state_d = ST_XFER;
            ST_XFER: begin
                if (final_beat)       state_d = ST_IDLE;
                else if (interleave)  state_d = ST_XFER;
                else                  state_d = ST_ACCESS;
            end
        endcase
    end

    // Outputs decoded from state.
    always_comb begin
        bank_start = '0;
        word_valid = 1'b0;
        word_last  = 1'b0;
        busy       = 1'b1;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_ADDR: begin
                if (interleave) bank_start = '1;
                else            bank_start = NBANK'(1);
            end
            ST_ACCESS: ;
            ST_XFER: begin
                word_valid = 1'b1;
                word_last  = final_beat;
                if (!interleave && !final_beat)
                    bank_start = NBANK'(1) << (beat_q + 1'b1);
            end
        endcase
    end

    assign beat = beat_q;

endmodule

// File: rtl/linefill_penalty.sv
module linefill_penalty #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             busy,
    input  logic             done_beat,
    output logic [CNT_W-1:0] penalty
);

    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] pen_q;

    // run_q equals the cycle number of the fill during each busy cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
            pen_q <= '0;
        end else begin
            if (accept)    run_q <= CNT_W'(1);
            else if (busy) run_q <= run_q + 1'b1;
            if (done_beat) pen_q <= run_q;
        end
    end

    assign penalty = pen_q;

endmodule

// File: rtl/linefill_ctrl.sv
module linefill_ctrl
    import linefill_pkg::*;
#(
    parameter int LINE_W = 16,
    parameter int NBANK  = 4,
    parameter int LAT    = 15,
    parameter int CNT_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [LINE_W-1:0]          req_line,
    input  logic                       req_interleave,
    output logic                       rsp_valid,
    output logic [DATA_W-1:0]          rsp_data,
    output logic [$clog2(NBANK)-1:0]   rsp_beat,
    output logic                       rsp_last,
    output logic [CNT_W-1:0]           penalty_cycles
);

    localparam int BEAT_W  = $clog2(NBANK);
    localparam int WADDR_W = LINE_W + BEAT_W;

    logic                 accept;
    logic                 busy;
    logic                 ilv_q;
    logic [LINE_W-1:0]    line_q;
    logic [NBANK-1:0]     bank_start;
    logic [NBANK-1:0]     bank_done;
    logic [DATA_W-1:0]    bank_data [NBANK];
    logic [BEAT_W-1:0]    beat;
    logic                 word_valid;
    logic                 word_last;

    assign req_ready = !busy;
    assign accept    = req_valid && !busy;

    // Request fields are held for the whole fill.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ilv_q  <= 1'b0;
            line_q <= '0;
        end else if (accept) begin
            ilv_q  <= req_interleave;
            line_q <= req_line;
        end
    end

    linefill_fsm #(.NBANK(NBANK), .BEAT_W(BEAT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .interleave (ilv_q),
        .bank_done  (bank_done),
        .bank_start (bank_start),
        .beat       (beat),
        .busy       (busy),
        .word_valid (word_valid),
        .word_last  (word_last)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        linefill_bank #(.LAT(LAT), .WADDR_W(WADDR_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .start (bank_start[b]),
            .waddr ({line_q, BEAT_W'(b)}),
            .done  (bank_done[b]),
            .data  (bank_data[b])
        );
    end

    linefill_penalty #(.CNT_W(CNT_W)) u_pen (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .busy      (busy),
        .done_beat (word_last),
        .penalty   (penalty_cycles)
    );

    assign rsp_valid = word_valid;
    assign rsp_last  = word_last;
    assign rsp_beat  = beat;
    assign rsp_data  = word_valid ? bank_data[beat] : '0;

endmodule

// File: rtl/linefill_ctrl_chk.sv
module linefill_ctrl_chk #(
    parameter int NBANK = 4,
    parameter int LAT   = 15,
    parameter int CNT_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_ready,
    input logic                     rsp_valid,
    input logic                     rsp_last,
    input logic [$clog2(NBANK)-1:0] rsp_beat,
    input logic [CNT_W-1:0]         penalty_cycles,
    input logic                     mode_q
);

    localparam int BW = $clog2(NBANK);
    localparam logic [CNT_W-1:0] PEN_ILV = CNT_W'(1 + LAT + NBANK);
    localparam logic [CNT_W-1:0] PEN_SEQ = CNT_W'(1 + NBANK * (LAT + 1));

    AST_BUSY_WHILE_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R2

    AST_LAST_ON_FINAL_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last |-> (rsp_valid && rsp_beat == BW'(NBANK - 1))); // R6

    AST_ILV_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_last && mode_q) |=>
            (rsp_valid && rsp_beat == BW'($past(rsp_beat) + 1'b1))); // R5

    AST_SEQ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_last && !mode_q) |=> !rsp_valid); // R4

    AST_PENALTY_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last |=> (penalty_cycles == ($past(mode_q) ? PEN_ILV : PEN_SEQ))); // R8

    AST_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last |=> req_ready); // R8

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> $stable(mode_q)); // R3

endmodule

bind linefill_ctrl linefill_ctrl_chk #(
    .NBANK (NBANK),
    .LAT   (LAT),
    .CNT_W (CNT_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_ready      (req_ready),
    .rsp_valid      (rsp_valid),
    .rsp_last       (rsp_last),
    .rsp_beat       (rsp_beat),
    .penalty_cycles (penalty_cycles),
    .mode_q         (ilv_q)
);

// File: tb/linefill_ctrl_tb.sv
module linefill_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_line = '0;
    logic        req_interleave = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic [1:0]  rsp_beat;
    logic        rsp_last;
    logic [7:0]  penalty_cycles;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    linefill_ctrl u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_line       (req_line),
        .req_interleave (req_interleave),
        .rsp_valid      (rsp_valid),
        .rsp_data       (rsp_data),
        .rsp_beat       (rsp_beat),
        .rsp_last       (rsp_last),
        .penalty_cycles (penalty_cycles)
    );

    // Stimulus table: {interleave, line}
    localparam logic [16:0] VEC [6] = '{
        {1'b0, 16'h0000}, {1'b1, 16'h0000}, {1'b0, 16'hFFFF},
        {1'b1, 16'hFFFF}, {1'b1, 16'h1234}, {1'b0, 16'h0ABC}
    };

    function automatic logic [31:0] exp_word(input logic [15:0] line, input int beat);
        logic [31:0] w;
        w = {14'b0, line, 2'(beat)};
        return (w * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            finish_run();
        end
    end

    // One fill: noise toggles fields and request pulses while busy (R2, R3).
    task automatic run_fill(input bit ilv, input logic [15:0] line, input bit noise);
        int total;
        total = ilv ? 20 : 65;
        @(negedge clk);
        check(req_ready == 1'b1, "R2 ready before request", req_ready, 1);
        req_valid = 1'b1; req_line = line; req_interleave = ilv;
        for (int n = 1; n <= total; n++) begin
            bit ev; int bt;
            @(negedge clk);
            if (ilv) begin
                ev = (n >= 17 && n <= 20);
                bt = n - 17;
            end else begin
                ev = (n >= 17 && ((n - 17) % 16) == 0);
                bt = (n - 17) / 16;
            end
            check(rsp_valid == ev, ilv ? "R5 strobe schedule" : "R4 strobe schedule", rsp_valid, ev);
            check(req_ready == 1'b0, "R2 ready low while busy", req_ready, 0);
            if (ev) begin
                check(rsp_beat == 2'(bt), "R6 beat order", rsp_beat, bt);
                check(rsp_last == (bt == 3), "R6 last flag", rsp_last, bt == 3);
                check(rsp_data == exp_word(line, bt), "R7 data", rsp_data, exp_word(line, bt));
            end else begin
                check(rsp_last == 1'b0, "R6 last idle", rsp_last, 0);
            end
            if (noise && n < total) begin
                req_valid = n[0];
                req_interleave = ~ilv;
                req_line = ~line;
            end else begin
                req_valid = 1'b0;
            end
        end
        @(negedge clk);
        check(req_ready == 1'b1, "R8 ready after last", req_ready, 1);
        check(penalty_cycles == 8'(total), "R8 penalty", penalty_cycles, total);
        check(rsp_valid == 1'b0, "R2 no spurious fill", rsp_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        check(rsp_valid == 1'b0, "R1 valid after reset", rsp_valid, 0);
        check(rsp_last == 1'b0, "R1 last after reset", rsp_last, 0);
        check(penalty_cycles == 8'd0, "R1 penalty after reset", penalty_cycles, 0);
        rst_n = 1'b1;

        foreach (VEC[i]) run_fill(VEC[i][16], VEC[i][15:0], i % 2 == 0);

        // R3: fields changed during the fill, result must match captured values
        run_fill(1'b0, 16'h5555, 1'b1);
        run_fill(1'b1, 16'hAAAA, 1'b1);

        // R8: penalty holds while idle
        repeat (5) @(negedge clk);
        check(penalty_cycles == 8'd20, "R8 penalty held", penalty_cycles, 20);

        // R9: reset mid-fill
        @(negedge clk);
        req_valid = 1'b1; req_line = 16'h0F0F; req_interleave = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (20) @(negedge clk);
        check(rsp_valid == 1'b0 && req_ready == 1'b0, "R9 mid-fill busy", req_ready, 0);
        rst_n = 1'b0;
        #1;
        check(req_ready == 1'b1, "R9 ready after abort", req_ready, 1);
        check(rsp_valid == 1'b0, "R9 valid after abort", rsp_valid, 0);
        check(penalty_cycles == 8'd0, "R9 penalty after abort", penalty_cycles, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(rsp_valid == 1'b0, "R9 no residual word", rsp_valid, 0);
        run_fill(1'b1, 16'h0F0F, 1'b0);

        finish_run();
    end

endmodule